// File: doc/BRIEF.md
# Relocatable Local-Bus Scratchpad Memory

This block is a 4 KB scratchpad memory that sits on a processor's local bus next to the cache. Every instruction fetch and data access goes to the cache and to this block at the same time. The block compares the address with a window that software can move in 32 KB steps. On a hit, the block answers instead of the cache. It tells the cache to throw away its own read result, and it marks the data as not to be cached.

A single configuration word sets where the window sits, which access types (instruction, data or both) may hit it, and whether the window is on at all. Accesses can be bytes, halfwords or full words, and each one touches only its own byte lanes. Requests from the debug port are treated the same as core requests. Requests from DMA masters never hit. Requests may arrive one per cycle, and each gets a response exactly one cycle later.

Top module: `lsram_top`

## Requirements
- R1: After reset the window is disabled: no request hits and `rsp_valid` is low. Clearing bit 0 of the configuration word disables the window again, and then no request hits.
- R2: When the window is enabled, a request hits only if `req_addr[31:15]` equals `cfg_wdata[31:15]` as last written, and `req_addr[14:12]` is zero. Configuration bits 14 to 3 have no effect. Moving the base keeps the stored contents: offset N under the new base reads what was written at offset N under the old base.
- R3: Configuration bit 1 allows data requests (`req_insn`=0) and bit 2 allows instruction requests (`req_insn`=1). A request whose type is not allowed does not hit.
- R4: Requests with `req_src` = 2 (DMA) or 3 (reserved) never hit. Their writes leave the memory unchanged.
- R5: Requests with `req_src` = 1 (debug) hit, read and write exactly as requests with `req_src` = 0 (core) do.
- R6: `req_size` 0 is a byte, 1 is a halfword and 2 is a word. Byte k of the word occupies `wdata`/`rdata` bits [8k+7:8k], and k = `req_addr[1:0]` for a byte, or `req_addr[1:0]` and `req_addr[1:0]`+1 for a halfword. A write updates only those lanes.
- R7: One cycle after a read hit, `rsp_rdata` carries the stored bytes in the addressed lanes and zero in the other lanes. After every other request it is all zero.
- R8: A hit with `req_size` 3, a halfword at an odd address, or a word whose `req_addr[1:0]` is not zero raises `rsp_err` one cycle later. Such a request writes nothing and returns zero data.
- R9: One cycle after each hit, `rsp_hit` and `rsp_nocache` are high. `rsp_kill_cache` is high only for read hits. All three are low after a miss.
- R10: Every request (`req_valid` high) is answered by `rsp_valid` exactly one cycle later, with no gaps on back-to-back requests. A read issued in the cycle right after a write to the same word returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word: [31:15] base, [2] instruction allow, [1] data allow, [0] enable |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_insn | input | 1 | 1 = instruction fetch, 0 = data access |
| req_src | input | 2 | Requester: 0 core, 1 debug, 2 DMA, 3 reserved |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, already placed on its byte lanes |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_hit | output | 1 | The previous request fell in the window |
| rsp_nocache | output | 1 | The returned data must not be allocated in the cache |
| rsp_kill_cache | output | 1 | Discard the cache's read result |
| rsp_err | output | 1 | The previous hit was misaligned or had a reserved size |
| rsp_rdata | output | 32 | Read data, lane-masked |

## Verification
The assertions assume that `rst_n` is held low long enough to clear the registers. They also assume that every request input is stable and known whenever `req_valid` is high, and that the configuration is never rewritten in the same cycle as a request that relies on it. The bench changes inputs only at the falling edge. It writes the configuration only in its own cycle, with no request beside it, and during reset it holds `req_valid` low, so the stimulus always stays within these assumptions.

// File: rtl/lsram_pkg.sv
package lsram_pkg;

    // Access width encodings on req_size
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    // Requester encodings on req_src
    typedef enum logic [1:0] {
        SRC_CORE  = 2'd0,
        SRC_DEBUG = 2'd1,
        SRC_DMA   = 2'd2,
        SRC_RSVD  = 2'd3
    } src_e;

    // Positions of the attribute bits in the configuration word
    localparam int CFG_BIT_EN   = 0;
    localparam int CFG_BIT_DATA = 1;
    localparam int CFG_BIT_INSN = 2;

endpackage

// File: rtl/lsram_basecfg.sv
module lsram_basecfg
    import lsram_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WIN_LSB = 15
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         wdata_i,
    output logic [ADDR_W-1:WIN_LSB]   base_o,
    output logic                      en_o,
    output logic                      allow_data_o,
    output logic                      allow_insn_o
);

    typedef struct packed {
        logic [ADDR_W-1:WIN_LSB] base;
        logic                    en;
        logic                    allow_d;
        logic                    allow_i;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Bits between the attribute field and the base field are reserved
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^wdata_i[WIN_LSB-1:0];

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            cfg_d.base    = wdata_i[ADDR_W-1:WIN_LSB];
            cfg_d.en      = wdata_i[CFG_BIT_EN];
            cfg_d.allow_d = wdata_i[CFG_BIT_DATA];
            cfg_d.allow_i = wdata_i[CFG_BIT_INSN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign base_o       = cfg_q.base;
    assign en_o         = cfg_q.en;
    assign allow_data_o = cfg_q.allow_d;
    assign allow_insn_o = cfg_q.allow_i;

endmodule

// File: rtl/lsram_decode.sv
module lsram_decode
    import lsram_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int WIN_LSB  = 15,
    parameter int SPAN_LSB = 12
) (
    input  logic [ADDR_W-1:0]                       addr_i,
    input  logic [1:0]                              size_i,
    input  logic [1:0]                              src_i,
    input  logic                                    insn_i,
    input  logic [ADDR_W-1:WIN_LSB]                 base_i,
    input  logic                                    en_i,
    input  logic                                    allow_data_i,
    input  logic                                    allow_insn_i,
    output logic                                    hit_o,
    output logic                                    misalign_o,
    output logic [DATA_W/8-1:0]                     lanes_o,
    output logic [SPAN_LSB-$clog2(DATA_W/8)-1:0]    idx_o
);

    localparam int BYTES = DATA_W / 8;
    localparam int OFF_W = $clog2(BYTES);
    localparam int IDX_W = SPAN_LSB - OFF_W;

    logic             base_match;
    logic             span_match;
    logic             type_ok;
    logic             src_ok;
    logic [OFF_W-1:0] off;

    assign off        = addr_i[OFF_W-1:0];
    assign base_match = (addr_i[ADDR_W-1:WIN_LSB] == base_i);
    assign span_match = (addr_i[WIN_LSB-1:SPAN_LSB] == '0);
    assign type_ok    = insn_i ? allow_insn_i : allow_data_i;
    assign src_ok     = (src_i == SRC_CORE) || (src_i == SRC_DEBUG);
    assign hit_o      = en_i && base_match && span_match && type_ok && src_ok;
    assign idx_o      = addr_i[SPAN_LSB-1:OFF_W];

    always_comb begin
        lanes_o    = '0;
        misalign_o = 1'b0;
        unique case (size_e'(size_i))
            SZ_BYTE: begin
                lanes_o = BYTES'(1) << off;
            end
            SZ_HALF: begin
                lanes_o    = BYTES'(3) << off;
                misalign_o = off[0];
            end
            SZ_WORD: begin
                lanes_o    = '1;
                misalign_o = (off != '0);
            end
            default: begin
                lanes_o    = '0;
                misalign_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/lsram_array.sv
module lsram_array #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic                     re_i,
    input  logic [DATA_W/8-1:0]      be_i,
    input  logic [$clog2(DEPTH)-1:0] idx_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [DATA_W-1:0]        rdata_o
);

    localparam int BYTES = DATA_W / 8;

    // One byte-wide bank per lane; the storage itself carries no reset.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [7:0] bank [DEPTH];
        logic [7:0] rd_d, rd_q;

        always_ff @(posedge clk) begin
            if (we_i && be_i[b]) begin
                bank[idx_i] <= wdata_i[8*b +: 8];
            end
        end

        always_comb begin
            rd_d = rd_q;
            if (re_i) begin
                rd_d = bank[idx_i];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_q <= '0;
            end else begin
                rd_q <= rd_d;
            end
        end

        assign rdata_o[8*b +: 8] = rd_q;
    end

    // R6: a write always carries at least one lane and never coincides with a read
    a_r6_write_has_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (be_i != '0) && !re_i);

endmodule

// File: rtl/lsram_top.sv
module lsram_top
    import lsram_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 1024,
    parameter int WIN_LSB  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_insn,
    input  logic [1:0]        req_src,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_nocache,
    output logic              rsp_kill_cache,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata
);

    localparam int BYTES    = DATA_W / 8;
    localparam int IDX_W    = $clog2(DEPTH);
    localparam int SPAN_LSB = IDX_W + $clog2(BYTES);

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             err;
        logic             rd;
        logic [BYTES-1:0] lanes;
    } rsp_ctl_t;

    logic [ADDR_W-1:WIN_LSB] cfg_base;
    logic                    cfg_en, cfg_allow_d, cfg_allow_i;
    logic                    dec_hit, dec_misalign;
    logic [BYTES-1:0]        dec_lanes;
    logic [IDX_W-1:0]        dec_idx;
    logic                    arr_we, arr_re;
    logic [DATA_W-1:0]       arr_rdata;
    logic [DATA_W-1:0]       lane_mask;
    rsp_ctl_t                ctl_d, ctl_q;

    lsram_basecfg #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_i         (cfg_we),
        .wdata_i      (cfg_wdata),
        .base_o       (cfg_base),
        .en_o         (cfg_en),
        .allow_data_o (cfg_allow_d),
        .allow_insn_o (cfg_allow_i)
    );

    lsram_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LSB(WIN_LSB), .SPAN_LSB(SPAN_LSB)
    ) u_dec (
        .addr_i       (req_addr),
        .size_i       (req_size),
        .src_i        (req_src),
        .insn_i       (req_insn),
        .base_i       (cfg_base),
        .en_i         (cfg_en),
        .allow_data_i (cfg_allow_d),
        .allow_insn_i (cfg_allow_i),
        .hit_o        (dec_hit),
        .misalign_o   (dec_misalign),
        .lanes_o      (dec_lanes),
        .idx_o        (dec_idx)
    );

    assign arr_we = req_valid && dec_hit && req_write  && !dec_misalign;
    assign arr_re = req_valid && dec_hit && !req_write && !dec_misalign;

    lsram_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (arr_we),
        .re_i    (arr_re),
        .be_i    (dec_lanes),
        .idx_i   (dec_idx),
        .wdata_i (req_wdata),
        .rdata_o (arr_rdata)
    );

    always_comb begin
        ctl_d       = '0;
        ctl_d.valid = req_valid;
        ctl_d.hit   = req_valid && dec_hit;
        ctl_d.err   = req_valid && dec_hit && dec_misalign;
        ctl_d.rd    = req_valid && dec_hit && !req_write;
        ctl_d.lanes = dec_lanes;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_mask
        assign lane_mask[8*b +: 8] = {8{ctl_q.lanes[b]}};
    end

    assign rsp_valid      = ctl_q.valid;
    assign rsp_hit        = ctl_q.hit;
    assign rsp_nocache    = ctl_q.hit;
    assign rsp_kill_cache = ctl_q.rd;
    assign rsp_err        = ctl_q.err;
    assign rsp_rdata      = (ctl_q.rd && !ctl_q.err) ? (arr_rdata & lane_mask) : '0;

    // R10: each request gets exactly one response one cycle later
    a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R9: discard of the cache result only comes with a non-cacheable hit
    a_r9_kill_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_kill_cache |-> rsp_hit && rsp_nocache && rsp_valid);
    // R8: an error is only reported for a hit, and a faulting access writes nothing
    a_r8_err_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_hit && (rsp_rdata == '0));
    a_r8_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        dec_misalign |-> !arr_we);
    // R4: DMA or reserved sources never hit
    a_r4_dma_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src[1]) |=> !rsp_hit);
    // R1: a disabled window decodes nothing
    a_r1_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !dec_hit);

endmodule

// File: tb/sim_lsram_top.sv
`timescale 1ns/1ps
module sim_lsram_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic        req_valid, req_write, req_insn;
    logic [1:0]  req_src, req_size;
    logic [31:0] req_addr, req_wdata;
    logic        rsp_valid, rsp_hit, rsp_nocache, rsp_kill_cache, rsp_err;
    logic [31:0] rsp_rdata;

    always #2 clk = ~clk;

    lsram_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_insn(req_insn),
        .req_src(req_src), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_nocache(rsp_nocache), .rsp_kill_cache(rsp_kill_cache),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    typedef struct {
        logic        hit;
        logic        kill;
        logic        err;
        logic [31:0] rdata;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          total = 0;
    int          bad   = 0;
    bit          done  = 1'b0;

    // Reference state, built only from the requirements
    logic [31:0] ref_mem [1024];
    logic [16:0] m_base = '0;
    logic        m_en = 1'b0, m_d = 1'b0, m_i = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cfg(input logic [31:0] v);
        cfg_we = 1'b1; cfg_wdata = v; req_valid = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        m_base = v[31:15]; m_en = v[0]; m_d = v[1]; m_i = v[2];
    endtask

    task automatic acc(input logic wr, input logic [1:0] sz, input logic [1:0] src,
                       input logic ins, input logic [31:0] a, input logic [31:0] wd,
                       input string tag);
        exp_t        e;
        logic        hit, mis;
        logic [3:0]  ln;
        logic [31:0] mask;
        req_valid = 1'b1; req_write = wr; req_size = sz; req_src = src;
        req_insn = ins; req_addr = a; req_wdata = wd;
        hit = m_en && (a[31:15] == m_base) && (a[14:12] == 3'd0) && !src[1]
              && (ins ? m_i : m_d);
        mis = (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'd0);
        case (sz)
            2'd0:    ln = 4'b0001 << a[1:0];
            2'd1:    ln = 4'b0011 << a[1:0];
            2'd2:    ln = 4'b1111;
            default: ln = 4'b0000;
        endcase
        mask = '0;
        for (int b = 0; b < 4; b++) if (ln[b]) mask[8*b +: 8] = 8'hFF;
        e.hit  = hit;
        e.kill = hit && !wr;
        e.err  = hit && mis;
        e.rdata = (hit && !mis && !wr) ? (ref_mem[a[11:2]] & mask) : 32'h0;
        e.tag  = tag;
        if (hit && !mis && wr)
            ref_mem[a[11:2]] = (ref_mem[a[11:2]] & ~mask) | (wd & mask);
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare each response with the oldest expected item
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_valid && rsp_hit == e.hit && rsp_nocache == e.hit &&
                      rsp_kill_cache == e.kill && rsp_err == e.err &&
                      rsp_rdata == e.rdata, e.tag, "response",
                      {rsp_valid, rsp_hit, rsp_nocache, rsp_kill_cache, rsp_err,
                       rsp_rdata[26:0]},
                      {1'b1, e.hit, e.hit, e.kill, e.err, e.rdata[26:0]});
                if (rsp_rdata != e.rdata)
                    check(1'b0, e.tag, "rdata", rsp_rdata, e.rdata);
            end else if (rsp_valid) begin
                check(1'b0, "R10", "unexpected rsp_valid", 32'd1, 32'd0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam logic [31:0] B0 = 32'h2000_8000;
    localparam logic [31:0] B1 = 32'h0001_0000;

    initial begin
        for (int k = 0; k < 1024; k++) ref_mem[k] = 32'h0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; req_valid = 1'b0;
        req_write = 1'b0; req_insn = 1'b0; req_src = 2'd0; req_size = 2'd2;
        req_addr = '0; req_wdata = '0;
        repeat (4) @(negedge clk);
        // R1: outputs idle in reset
        check(!rsp_valid && !rsp_hit && !rsp_err && rsp_rdata == 0, "R1",
              "reset outputs", {rsp_valid, rsp_hit, rsp_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: nothing hits before the window is enabled
        acc(1'b0, 2'd2, 2'd0, 1'b0, 32'h0000_0000, 32'h0, "R1");
        acc(1'b1, 2'd2, 2'd0, 1'b0, B0, 32'hDEAD_BEEF, "R1");
        // R2: enable at B0, both types, junk in reserved bits 14..3
        cfg(B0 | 32'h0000_7FF8 | 32'h7);
        // R10: back-to-back writes then reads, read right after write
        acc(1'b1, 2'd2, 2'd0, 1'b0, B0 + 0, 32'h1111_2222, "R10");
        acc(1'b0, 2'd2, 2'd0, 1'b0, B0 + 0, 32'h0, "R10");
        acc(1'b1, 2'd2, 2'd0, 1'b0, B0 + 4, 32'hA5A5_5A5A, "R10");
        acc(1'b1, 2'd2, 2'd0, 1'b0, B0 + 32'hFFC, 32'hCAFE_F00D, "R2");
        acc(1'b0, 2'd2, 2'd0, 1'b0, B0 + 4, 32'h0, "R7");
        acc(1'b0, 2'd2, 2'd0, 1'b1, B0 + 32'hFFC, 32'h0, "R9");
        // R2: outside the 4 KB span or another base
        acc(1'b0, 2'd2, 2'd0, 1'b0, B0 + 32'h1000, 32'h0, "R2");
        acc(1'b0, 2'd2, 2'd0, 1'b0, B0 ^ 32'h0000_8000, 32'h0, "R2");
        idle();
        // R6: byte and halfword writes on each lane
        acc(1'b1, 2'd2, 2'd0, 1'b0, B0 + 8, 32'h0000_0000, "R6");
        for (int k = 0; k < 4; k++)
            acc(1'b1, 2'd0, 2'd0, 1'b0, B0 + 8 + k, 32'h1122_3344 + 32'h0101_0101 * k, "R6");
        acc(1'b0, 2'd2, 2'd0, 1'b0, B0 + 8, 32'h0, "R6");
        acc(1'b1, 2'd1, 2'd0, 1'b0, B0 + 10, 32'hBEEF_0000, "R6");
        acc(1'b0, 2'd2, 2'd0, 1'b0, B0 + 8, 32'h0, "R6");
        // R7: narrow reads zero the other lanes
        for (int k = 0; k < 4; k++)
            acc(1'b0, 2'd0, 2'd0, 1'b0, B0 + 4 + k, 32'h0, "R7");
        acc(1'b0, 2'd1, 2'd0, 1'b0, B0 + 6, 32'h0, "R7");
        // R8: misaligned and reserved size, then memory unchanged
        acc(1'b1, 2'd1, 2'd0, 1'b0, B0 + 5, 32'hFFFF_FFFF, "R8");
        acc(1'b1, 2'd2, 2'd0, 1'b0, B0 + 6, 32'hFFFF_FFFF, "R8");
        acc(1'b1, 2'd3, 2'd0, 1'b0, B0 + 4, 32'hFFFF_FFFF, "R8");
        acc(1'b0, 2'd2, 2'd0, 1'b0, B0 + 7, 32'h0, "R8");
        acc(1'b0, 2'd2, 2'd0, 1'b0, B0 + 4, 32'h0, "R8");
        // R4: DMA and reserved sources ignored
        acc(1'b1, 2'd2, 2'd2, 1'b0, B0 + 4, 32'h0BAD_0BAD, "R4");
        acc(1'b1, 2'd2, 2'd3, 1'b0, B0 + 4, 32'h0BAD_0BAD, "R4");
        acc(1'b0, 2'd2, 2'd2, 1'b0, B0 + 4, 32'h0, "R4");
        acc(1'b0, 2'd2, 2'd0, 1'b0, B0 + 4, 32'h0, "R4");
        // R5: debug source behaves like the core
        acc(1'b1, 2'd2, 2'd1, 1'b0, B0 + 32'h100, 32'h5555_AAAA, "R5");
        acc(1'b0, 2'd0, 2'd1, 1'b0, B0 + 32'h101, 32'h0, "R5");
        acc(1'b0, 2'd2, 2'd1, 1'b1, B0 + 32'h100, 32'h0, "R5");
        // R3: attribute filtering
        cfg(B0 | 32'h3);
        acc(1'b0, 2'd2, 2'd0, 1'b1, B0, 32'h0, "R3");
        acc(1'b0, 2'd2, 2'd0, 1'b0, B0, 32'h0, "R3");
        cfg(B0 | 32'h5);
        acc(1'b0, 2'd2, 2'd0, 1'b0, B0, 32'h0, "R3");
        acc(1'b1, 2'd2, 2'd0, 1'b0, B0, 32'h7777_7777, "R3");
        acc(1'b0, 2'd2, 2'd0, 1'b1, B0, 32'h0, "R3");
        // R2: relocation keeps contents, old base no longer hits
        cfg(B1 | 32'h7);
        acc(1'b0, 2'd2, 2'd0, 1'b0, B1 + 4, 32'h0, "R2");
        acc(1'b0, 2'd2, 2'd0, 1'b0, B0 + 4, 32'h0, "R2");
        acc(1'b0, 2'd2, 2'd0, 1'b1, B1 + 32'hFFC, 32'h0, "R2");
        // R1: disabling silences the window
        cfg(B1 | 32'h6);
        acc(1'b0, 2'd2, 2'd0, 1'b0, B1 + 4, 32'h0, "R1");
        acc(1'b1, 2'd2, 2'd0, 1'b0, B1 + 4, 32'h1234_5678, "R1");
        cfg(B1 | 32'h7);
        acc(1'b0, 2'd2, 2'd0, 1'b0, B1 + 4, 32'h0, "R1");
        idle();
        idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule